// File: doc/BRIEF.md
# Dual-Mode Serial Readout for a Two-Channel SAR Converter

This block is the digital side of a two-channel successive-approximation converter with a serial port. A host frames each transaction by pulling the active-low chip select low and toggling the serial clock. The block counts serial-clock edges inside that window. It emits a sample strobe when the window opens and a conversion-done strobe when enough rising edges have passed, and at that point it captures the parallel code supplied by the analog stand-in. It shifts a result out MSB first on the serial data line.

The frame length selects one of two readout modes. If chip select returns high early, the block stays in the short mode, where each frame carries the previous conversion. If chip select is still low at the thirtieth falling edge, the block switches to the long mode. In that mode the current result follows in the second half of the same frame, and the first half of the next frame is zero-filled. A power-down request pin is looked at only when chip select rises. A granted request takes effect after the next conversion and stays in force until a later chip-select rise finds the pin low. Chip select and serial clock are assumed to be already synchronous to the block clock and slower than it, and edges are found by comparing each input with its registered copy.

Top module: `sar_serial_if`

## Requirements
- R1: A falling chip-select edge produces a one-cycle `sample_stb` and enables `sdo_oe`, with the first data bit on `sdo` straight away.
- R2: After the k-th serial-clock falling edge of a frame, `sdo` carries data bit position k. Codes are straight binary and sent MSB first.
- R3: `conv_done_stb` pulses once per frame, after rising edge 14 (12-bit), 11 (10-bit) or 9 (8-bit). At that point the block latches `conv_data` as the new result.
- R4: In a frame that follows a short frame, positions 0..RES-1 carry the previously latched result. Positions RES..15 are 0.
- R5: When chip select is still low at falling edge 30, the frame is long. Positions 16..16+RES-1 of that frame carry the result latched in that same frame. Later positions are 0.
- R6: In the frame after a long frame, positions 0..15 are all 0.
- R7: While chip select is high, `sdo_oe` is 0.
- R8: `pd_req` has an effect only at a chip-select rising edge. If it is high there, `pd_state` rises after the conversion of the following frame and not before it, and serial data continues to be shifted out.
- R9: `pd_state` holds while chip select stays low. A chip-select rising edge with `pd_req` low clears it.
- R10: The level of `chan_sel` at the first serial-clock rising edge of a frame appears on `chan_q` (0 selects channel 0, 1 selects channel 1).
- R11: After reset the latched result is 0, the mode is short, `pd_state` is 0 and `chan_q` is 0.
- R12: A frame whose chip select rises before the conversion edge produces no `conv_done_stb` and leaves the latched result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| chan_sel | input | 1 | Channel choice for the next sample |
| pd_req | input | 1 | Power-down request, looked at on chip-select rise |
| conv_data | input | RES | Parallel code from the analog stand-in |
| sdo | output | 1 | Serial data, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| sample_stb | output | 1 | One-cycle pulse when sampling starts |
| conv_done_stb | output | 1 | One-cycle pulse when conversion completes |
| pd_state | output | 1 | Power-down state flag |
| chan_q | output | 1 | Captured channel choice |

## Verification
The readout is driven through a chain of frames of different lengths: short after reset, short after short, long, short after long, and a short frame that is aborted. Each of these tells apart one data source for a bit position: zero after reset, the previous code, the same-frame code, or the zero-filled lead-in. Distinct bit patterns in consecutive codes make any swap between the previous and current result visible. A pulse on the power-down pin in the middle of a frame is set against a level held at the chip-select rise, which separates edge sampling from level sensing. Entry into and exit from power-down are checked on both sides of the conversion edge.

// File: rtl/sif_pkg.sv
// Package: shared helpers for the serial readout block.
// Assumes resolution is one of 12, 10 or 8 bits.
package sif_pkg;

    // Number of serial-clock rising edges that end a conversion.
    function automatic int conv_edge_count(input int res);
        return (res == 12) ? 14 : res + 1;
    endfunction

endpackage

// File: rtl/sif_edge_sense.sv
// Module: registers chip select and serial clock and flags their edges.
// Assumes both inputs are already synchronous to clk and change slower than it.
module sif_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic sel,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic in_frame
);
    logic cs_q;
    logic sclk_q;

    // Keep the previous level of each serial pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    // Edge flags from the registered and present levels.
    always_comb begin
        sel       = ~cs_q;
        cs_fall   = cs_q & ~cs_n;
        cs_rise   = ~cs_q & cs_n;
        sclk_rise = ~sclk_q & sclk;
        sclk_fall = sclk_q & ~sclk;
        in_frame  = ~cs_q & ~cs_n;
    end

endmodule

// File: rtl/sif_frame_ctrl.sv
// Module: counts serial-clock edges within a frame and tracks the result,
// the readout mode, the power-down state and the captured channel.
// Assumes edge flags come from sif_edge_sense, one clk wide.
module sif_frame_ctrl #(
    parameter int RES        = 12,
    parameter int HALF_CLKS  = 16,
    parameter int LONG_FALLS = 30,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             in_frame,
    input  logic             chan_sel,
    input  logic             pd_req,
    input  logic [RES-1:0]   conv_data,
    output logic [CNT_W-1:0] fall_cnt,
    output logic             lead_zero,
    output logic [RES-1:0]   result,
    output logic             sample_stb,
    output logic             conv_done_stb,
    output logic             pd_state,
    output logic             chan_q
);
    import sif_pkg::*;

    localparam int CONV_EDGES = conv_edge_count(RES);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_EDGES - 1);
    localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_FALLS - 1);

    logic [CNT_W-1:0] rise_cnt;
    logic             long_seen;
    logic             pd_arm;

    // Frame sequencing: edge counters, conversion, mode and power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_cnt      <= '0;
            rise_cnt      <= '0;
            long_seen     <= 1'b0;
            lead_zero     <= 1'b0;
            result        <= '0;
            sample_stb    <= 1'b0;
            conv_done_stb <= 1'b0;
            pd_state      <= 1'b0;
            pd_arm        <= 1'b0;
            chan_q        <= 1'b0;
        end else begin
            sample_stb    <= cs_fall;
            conv_done_stb <= 1'b0;
            if (cs_fall) begin
                fall_cnt  <= '0;
                rise_cnt  <= '0;
                long_seen <= 1'b0;
            end else if (in_frame) begin
                if (sclk_rise) begin
                    if (rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
                    if (rise_cnt == '0) chan_q <= chan_sel;
                    if (rise_cnt == CONV_LAST) begin
                        conv_done_stb <= 1'b1;
                        result        <= conv_data;
                        if (pd_arm) pd_state <= 1'b1;
                    end
                end
                if (sclk_fall) begin
                    if (fall_cnt != '1) fall_cnt <= fall_cnt + 1'b1;
                    if (fall_cnt == LONG_LAST) long_seen <= 1'b1;
                end
            end
            if (cs_rise) begin
                lead_zero <= long_seen;
                pd_arm    <= pd_req;
                if (!pd_req) pd_state <= 1'b0;
            end
        end
    end

    AST_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_stb |-> $past(!cs_n)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && conv_done_stb)); // R1
    AST_PD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !pd_req) |=> !pd_state); // R9
    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_state && !cs_rise) |=> pd_state); // R9

endmodule

// File: rtl/sif_bit_select.sv
// Module: picks the serial data bit for the current falling-edge count.
// Assumes the result register holds the previous code until the conversion edge.
module sif_bit_select #(
    parameter int RES       = 12,
    parameter int HALF_CLKS = 16,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [CNT_W-1:0] fall_cnt,
    input  logic             lead_zero,
    input  logic [RES-1:0]   result,
    output logic             sdo
);
    logic bit_v;

    // Map the falling-edge count onto a result bit or a zero fill.
    always_comb begin
        int k;
        k     = int'(fall_cnt);
        bit_v = 1'b0;
        if (k < HALF_CLKS) begin
            if (!lead_zero && k < RES) bit_v = result[RES-1-k];
        end else if (k - HALF_CLKS < RES) begin
            bit_v = result[RES-1-(k-HALF_CLKS)];
        end
        sdo = sel & bit_v;
    end

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && lead_zero && int'(fall_cnt) < HALF_CLKS) |-> !sdo); // R6
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && int'(fall_cnt) >= RES && int'(fall_cnt) < HALF_CLKS) |-> !sdo); // R4

endmodule

// File: rtl/sar_serial_if.sv
// Module: top of the serial readout for a two-channel SAR converter.
// Assumes cs_n and sclk are synchronous to clk; the pad ring builds the
// tri-state buffer from sdo and sdo_oe.
module sar_serial_if #(
    parameter int RES        = 12,
    parameter int HALF_CLKS  = 16,
    parameter int LONG_FALLS = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic           chan_sel,
    input  logic           pd_req,
    input  logic [RES-1:0] conv_data,
    output logic           sdo,
    output logic           sdo_oe,
    output logic           sample_stb,
    output logic           conv_done_stb,
    output logic           pd_state,
    output logic           chan_q
);
    localparam int CNT_W = $clog2(HALF_CLKS + LONG_FALLS);

    logic             sel;
    logic             cs_fall;
    logic             cs_rise;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             in_frame;
    logic [CNT_W-1:0] fall_cnt;
    logic             lead_zero;
    logic [RES-1:0]   result;

    sif_edge_sense u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sel       (sel),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .in_frame  (in_frame)
    );

    sif_frame_ctrl #(
        .RES        (RES),
        .HALF_CLKS  (HALF_CLKS),
        .LONG_FALLS (LONG_FALLS),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .cs_fall       (cs_fall),
        .cs_rise       (cs_rise),
        .sclk_rise     (sclk_rise),
        .sclk_fall     (sclk_fall),
        .in_frame      (in_frame),
        .chan_sel      (chan_sel),
        .pd_req        (pd_req),
        .conv_data     (conv_data),
        .fall_cnt      (fall_cnt),
        .lead_zero     (lead_zero),
        .result        (result),
        .sample_stb    (sample_stb),
        .conv_done_stb (conv_done_stb),
        .pd_state      (pd_state),
        .chan_q        (chan_q)
    );

    sif_bit_select #(
        .RES       (RES),
        .HALF_CLKS (HALF_CLKS),
        .CNT_W     (CNT_W)
    ) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .fall_cnt  (fall_cnt),
        .lead_zero (lead_zero),
        .result    (result),
        .sdo       (sdo)
    );

    // Pad enable follows the registered frame select.
    assign sdo_oe = sel;

    AST_SDO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe); // R7

endmodule

// File: tb/sar_serial_if_tb.sv
module sar_serial_if_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RES        = 12;
    localparam int CONV       = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cs_n = 1'b1;
    logic           sclk = 1'b0;
    logic           chan_sel = 1'b0;
    logic           pd_req = 1'b0;
    logic [RES-1:0] conv_data = '0;
    logic           sdo, sdo_oe, sample_stb, conv_done_stb, pd_state, chan_q;

    int n_checks = 0;
    int n_fail   = 0;
    int n_samp   = 0;
    int n_done   = 0;

    // model state
    logic [RES-1:0] m_prev = '0;
    logic           m_lead = 1'b0;

    sar_serial_if #(.RES(RES)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .chan_sel(chan_sel), .pd_req(pd_req), .conv_data(conv_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .sample_stb(sample_stb),
        .conv_done_stb(conv_done_stb), .pd_state(pd_state), .chan_q(chan_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (sample_stb) n_samp++;
        if (conv_done_stb) n_done++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_bits(input int nclk, input logic lead,
                                              input logic [RES-1:0] pv, input logic [RES-1:0] cv);
        logic [31:0] v = '0;
        for (int k = 0; k < nclk && k < 32; k++) begin
            if (k < 16) v[k] = (!lead && k < RES) ? pv[RES-1-k] : 1'b0;
            else        v[k] = (k - 16 < RES) ? cv[RES-1-(k-16)] : 1'b0;
        end
        return v;
    endfunction

    // One frame of nclk serial clocks; records the bit at each falling-edge count.
    task automatic run_frame(input int nclk, input logic [RES-1:0] data, input logic ch,
                             input logic pd_at_rise, input logic pd_mid,
                             output logic [31:0] bits, output int done_rise,
                             output logic pd_pre, output logic pd_end,
                             output logic chan_seen, output logic oe0);
        int d0;
        conv_data = data;
        chan_sel  = ch;
        d0        = n_done;
        bits      = '0;
        done_rise = 0;
        pd_pre    = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        waitn(4);
        bits[0] = sdo;
        oe0     = sdo_oe;
        for (int i = 1; i <= nclk; i++) begin
            @(negedge clk) sclk = 1'b1;
            waitn(4);
            if (i == 1) pd_pre = pd_state;
            if (done_rise == 0 && n_done != d0) done_rise = i;
            if (pd_mid && i == 2) pd_req = 1'b1;
            if (pd_mid && i == 3) pd_req = 1'b0;
            @(negedge clk) sclk = 1'b0;
            waitn(4);
            if (i < 32 && i < nclk) bits[i] = sdo;
        end
        chan_seen = chan_q;
        pd_end    = pd_state;
        pd_req    = pd_at_rise;
        waitn(2);
        @(negedge clk) cs_n = 1'b1;
        waitn(3);
        pd_req = 1'b0;
        waitn(4);
        if (nclk >= CONV) m_prev = data;
        if (nclk >= CONV) m_lead = (nclk >= 30);
    endtask

    logic [31:0] bits;
    int          dr;
    logic        pp, pe, cq, oe;

    task automatic t_reset();
        check("R11 pd_state", 32'(pd_state), 32'd0);
        check("R11 chan_q", 32'(chan_q), 32'd0);
        check("R7 sdo_oe idle", 32'(sdo_oe), 32'd0);
    endtask

    task automatic t_first_frame();
        int s0 = n_samp;
        run_frame(16, 12'hA5C, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R11 zero prior result", bits, exp_bits(16, 1'b0, 12'h000, 12'h000));
        check("R3 done edge", 32'(dr), 32'(CONV));
        check("R1 sample strobe", 32'(n_samp - s0), 32'd1);
        check("R1 oe at frame start", 32'(oe), 32'd1);
        check("R7 sdo_oe after frame", 32'(sdo_oe), 32'd0);
    endtask

    task automatic t_short_prev();
        logic [RES-1:0] pv = m_prev;
        run_frame(16, 12'h3F1, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R4 R2 previous code", bits, exp_bits(16, 1'b0, pv, 12'h3F1));
    endtask

    task automatic t_long();
        logic [RES-1:0] pv = m_prev;
        run_frame(32, 12'hC36, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R5 same-frame code", bits, exp_bits(32, 1'b0, pv, 12'hC36));
        check("R3 done edge long", 32'(dr), 32'(CONV));
    endtask

    task automatic t_after_long();
        run_frame(16, 12'h5A9, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R6 zero lead-in", bits, 32'd0);
        run_frame(16, 12'h801, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R4 back to previous code", bits, exp_bits(16, 1'b0, 12'h5A9, 12'h801));
    endtask

    task automatic t_abort();
        int d0 = n_done;
        run_frame(4, 12'h0F0, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R12 no done strobe", 32'(n_done - d0), 32'd0);
        run_frame(16, 12'h123, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R12 result kept", bits, exp_bits(16, 1'b0, 12'h801, 12'h123));
    endtask

    task automatic t_channel();
        run_frame(16, 12'h456, 1'b1, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R10 channel 1", 32'(cq), 32'd1);
        run_frame(16, 12'h789, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R10 channel 0", 32'(cq), 32'd0);
    endtask

    task automatic t_power();
        logic [RES-1:0] pv;
        run_frame(16, 12'h111, 1'b0, 1'b0, 1'b1, bits, dr, pp, pe, cq, oe);
        run_frame(16, 12'h222, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R8 mid-frame pulse ignored", 32'(pe), 32'd0);
        run_frame(16, 12'h333, 1'b0, 1'b1, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R8 not yet down", 32'(pe), 32'd0);
        pv = m_prev;
        run_frame(16, 12'h444, 1'b0, 1'b0, 1'b0, bits, dr, pp, pe, cq, oe);
        check("R8 active before conversion", 32'(pp), 32'd0);
        check("R9 down held to frame end", 32'(pe), 32'd1);
        check("R8 data continues", bits, exp_bits(16, 1'b0, pv, 12'h444));
        check("R9 woken by rise", 32'(pd_state), 32'd0);
    endtask

    initial begin
        waitn(3);
        @(negedge clk) rst_n = 1'b1;
        waitn(2);
        t_reset();
        t_first_frame();
        t_short_prev();
        t_long();
        t_after_long();
        t_abort();
        t_channel();
        t_power();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule